// File: doc/BRIEF.md
# Multi-Mode Observer Register

This block is a small bank of flip-flops placed where a logic block meets its neighbours. A two-bit mode code, decoded again on every clock edge, turns the same three stages into one of four things. It can be an ordinary parallel register. It can be a serial shift chain, so that its contents can be shifted in and out. It can be a pseudo-random pattern source that also folds the parallel inputs into a running signature. It can also be cleared to zero.

In use, the register is first loaded or shifted to a nonzero seed. It is then held in the signature mode for a number of cycles while the logic under test drives its data inputs. Afterwards the result is shifted out through the serial output. With all data inputs at zero, the signature mode steps through every nonzero state before repeating.

The width and the feedback tap mask are parameters. The defaults are 3 stages, with feedback taken from stage 2 XOR stage 1.

Top module: `logic_observer_reg`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `q` becomes 0 on that edge, whatever the mode, data and serial input.
- R2: Mode code 2'b11 (load) copies `d` into `q` on the clock edge, with no shifting.
- R3: Mode code 2'b00 (scan) shifts the register on the clock edge: `q[0]` takes `si`, and `q[i]` takes the old `q[i-1]` for i ≥ 1. The data inputs have no effect in this mode.
- R4: `so` always equals the last stage, `q[WIDTH-1]`.
- R5: Mode code 2'b10 (clear) sets `q` to 0 on the clock edge. The data and serial inputs have no effect in this mode.
- R6: Mode code 2'b01 (signature) updates the register on the clock edge as follows:
  - `q[0]` takes `d[0]` XOR `q[2]` XOR `q[1]`.
  - `q[i]` takes `d[i]` XOR the old `q[i-1]` for i ≥ 1.
  - `si` has no effect in this mode.
- R7: In signature mode with `d` held at 0:
  - from any nonzero state, the register passes through all 7 nonzero states and returns to its start after exactly 7 edges;
  - from the all-zero state, it stays at zero.
- R8: Suppose two signature runs of equal length start from the same seed and use data sequences that differ in a single bit of a single cycle. Their final signatures differ.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode | input | 2 | 00 scan, 01 signature, 10 clear, 11 load |
| d | input | WIDTH | Parallel data (load value or signature input) |
| si | input | 1 | Serial scan input into stage 0 |
| q | output | WIDTH | Register contents |
| so | output | 1 | Serial scan output, last stage |

## Verification
Every mode writes the register on the very next edge, so a wrong internal state shows at `q` one cycle after the offending mode code. It reaches `so` after at most WIDTH further scan shifts. A wrong feedback tap only shows in signature mode: it either shortens the 7-state cycle or makes the final signature differ from the independently computed value. The bench therefore checks the cycle length and compares whole signature runs, including runs with a single flipped data bit.

// File: rtl/obs_pkg.sv
// Package: shared types for the observer register.
// Assumes a two-bit mode code whose values select the register function.
package obs_pkg;

    typedef enum logic [1:0] {
        MODE_SCAN  = 2'b00,
        MODE_SIG   = 2'b01,
        MODE_CLEAR = 2'b10,
        MODE_LOAD  = 2'b11
    } obs_mode_e;

    // One-hot function select produced by the decoder.
    typedef struct packed {
        logic scan;
        logic sig;
        logic clear;
        logic load;
    } obs_sel_t;

endpackage

// File: rtl/obs_mode_decode.sv
// Module: obs_mode_decode
// Turns the raw two-bit mode code into a one-hot select for the stages.
// Assumes the code is sampled each cycle; all four codes are legal.
module obs_mode_decode
    import obs_pkg::*;
(
    input  logic [1:0] mode,
    output obs_sel_t   sel
);

    // Purpose: map each mode code to exactly one select line.
    always_comb begin
        sel = '0;
        unique case (obs_mode_e'(mode))
            MODE_SCAN:  sel.scan  = 1'b1;
            MODE_SIG:   sel.sig   = 1'b1;
            MODE_CLEAR: sel.clear = 1'b1;
            MODE_LOAD:  sel.load  = 1'b1;
            default:    sel       = '0;
        endcase
    end

endmodule

// File: rtl/obs_feedback.sv
// Module: obs_feedback
// XOR reduction of the register stages selected by a tap mask.
// Assumes TAP_MASK picks a primitive polynomial for a maximal-length run.
module obs_feedback #(
    parameter int               WIDTH    = 3,
    parameter logic [WIDTH-1:0] TAP_MASK = 3'b110
) (
    input  logic [WIDTH-1:0] q,
    output logic             fb
);

    // Purpose: parity of the tapped stages.
    always_comb begin
        fb = ^(q & TAP_MASK);
    end

endmodule

// File: rtl/obs_stage.sv
// Module: obs_stage
// One bit of the observer: a mode-controlled mux in front of a flop.
// Assumes sel is one-hot and chain_in is the previous stage (or the
// serial input / feedback for stage 0).
module obs_stage
    import obs_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  obs_sel_t sel,
    input  logic     d_bit,
    input  logic     chain_in,
    output logic     q_bit
);

    logic nxt;

    // Purpose: pick the next value for this bit from the active function.
    always_comb begin
        nxt = q_bit;
        if (sel.scan)  nxt = chain_in;
        if (sel.sig)   nxt = chain_in ^ d_bit;
        if (sel.clear) nxt = 1'b0;
        if (sel.load)  nxt = d_bit;
    end

    // Purpose: storage flop with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) q_bit <= 1'b0;
        else        q_bit <= nxt;
    end

endmodule

// File: rtl/logic_observer_reg.sv
// Module: logic_observer_reg
// Multi-mode register at a logic block boundary: parallel load, scan
// shift, pseudo-random generation with signature compaction, and clear.
// Assumes WIDTH >= 2 and a mode code that is valid on every clock edge.
module logic_observer_reg
    import obs_pkg::*;
#(
    parameter int               WIDTH    = 3,
    parameter logic [WIDTH-1:0] TAP_MASK = 3'b110
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       mode,
    input  logic [WIDTH-1:0] d,
    input  logic             si,
    output logic [WIDTH-1:0] q,
    output logic             so
);

    localparam int LAST = WIDTH - 1;

    obs_sel_t         sel;
    logic             fb;
    logic [WIDTH-1:0] chain;

    obs_mode_decode u_dec (
        .mode (mode),
        .sel  (sel)
    );

    obs_feedback #(.WIDTH(WIDTH), .TAP_MASK(TAP_MASK)) u_fb (
        .q  (q),
        .fb (fb)
    );

    // Purpose: stage 0 is fed by the serial input in scan, feedback otherwise.
    always_comb begin
        chain[0] = sel.sig ? fb : si;
    end

    for (genvar i = 0; i < WIDTH; i++) begin : g_stage
        if (i > 0) begin : g_link
            // Purpose: each later stage follows the one before it.
            always_comb chain[i] = q[i-1];
        end
        obs_stage u_stage (
            .clk      (clk),
            .rst_n    (rst_n),
            .sel      (sel),
            .d_bit    (d[i]),
            .chain_in (chain[i]),
            .q_bit    (q[i])
        );
    end

    // Purpose: serial output is the last stage.
    always_comb so = q[LAST];

    assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b11) |=> (q == $past(d)));

    assert_scan_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b00) |=> (q == {$past(q[LAST-1:0]), $past(si)}));

    assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b10) |=> (q == '0));

    assert_sig_upper_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b01) |=> (q[LAST:1] == ($past(q[LAST-1:0]) ^ $past(d[LAST:1]))));

    assert_sig_zero_lock_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b01 && d == '0 && q == '0) |=> (q == '0));

endmodule

// File: tb/logic_observer_reg_test.sv
module logic_observer_reg_test;

    localparam int CLK_PERIOD = 10;
    localparam int SIG_LEN    = 20;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] mode;
    logic [2:0] d;
    logic       si;
    logic [2:0] q;
    logic       so;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic_observer_reg uut (
        .clk(clk), .rst_n(rst_n), .mode(mode), .d(d), .si(si), .q(q), .so(so)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // vector: {mode[1:0], d[2:0], si, expected q[2:0]}
    localparam logic [8:0] VEC [14] = '{
        {2'b11, 3'b101, 1'b0, 3'b101},  // R2 load
        {2'b00, 3'b111, 1'b0, 3'b010},  // R3 scan, d ignored
        {2'b00, 3'b000, 1'b1, 3'b101},  // R3
        {2'b00, 3'b000, 1'b1, 3'b011},  // R3
        {2'b01, 3'b000, 1'b1, 3'b111},  // R6 si ignored
        {2'b01, 3'b000, 1'b0, 3'b110},  // R6
        {2'b01, 3'b011, 1'b0, 3'b111},  // R6 data folded in
        {2'b10, 3'b101, 1'b1, 3'b000},  // R5 clear
        {2'b01, 3'b000, 1'b0, 3'b000},  // R7 zero lock
        {2'b01, 3'b001, 1'b0, 3'b001},  // R6 from zero
        {2'b11, 3'b110, 1'b1, 3'b110},  // R2
        {2'b10, 3'b111, 1'b1, 3'b000},  // R5
        {2'b00, 3'b111, 1'b1, 3'b001},  // R3
        {2'b11, 3'b010, 1'b0, 3'b010}   // R2
    };

    task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic step(input logic [1:0] m, input logic [2:0] dv, input logic s);
        @(negedge clk);
        mode = m; d = dv; si = s;
        @(posedge clk);
        #1;
    endtask

    function automatic logic [2:0] ref_sig(input logic [2:0] st, input logic [2:0] dv);
        return {st[1] ^ dv[2], st[0] ^ dv[1], st[2] ^ st[1] ^ dv[0]};
    endfunction

    function automatic logic [2:0] data_at(input int i);
        return 3'((i * 5 + 3) % 8);
    endfunction

    task automatic run_sig(input int flip_cyc, input int flip_bit, output logic [2:0] res);
        step(2'b11, 3'b100, 1'b0);
        for (int i = 0; i < SIG_LEN; i++) begin
            logic [2:0] dv = data_at(i);
            if (i == flip_cyc) dv[flip_bit] = ~dv[flip_bit];
            step(2'b01, dv, 1'b0);
        end
        res = q;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [2:0] model;
        logic [2:0] sig_a;
        logic [2:0] sig_b;
        logic [2:0] start;
        logic [7:0] seen;
        rst_n = 1'b0; mode = 2'b11; d = 3'b111; si = 1'b1;
        // R1: reset wins over load of all ones
        step(2'b11, 3'b111, 1'b1);
        step(2'b11, 3'b111, 1'b1);
        check("R1 reset", q, 3'b000);
        check("R4 so after reset", {2'b00, so}, 3'b000);
        @(negedge clk); rst_n = 1'b1;

        // table walk
        for (int k = 0; k < 14; k++) begin
            step(VEC[k][8:7], VEC[k][6:4], VEC[k][3]);
            check($sformatf("R2/R3/R5/R6 vector %0d", k), q, VEC[k][2:0]);
            check($sformatf("R4 so vector %0d", k), {2'b00, so}, {2'b00, VEC[k][2]});
        end

        // R1: reset during scan and signature
        step(2'b01, 3'b011, 1'b0);
        @(negedge clk); rst_n = 1'b0;
        step(2'b00, 3'b000, 1'b1);
        check("R1 reset in scan", q, 3'b000);
        @(negedge clk); rst_n = 1'b1;

        // R7: full period from each seed
        for (int s = 1; s < 8; s++) begin
            start = 3'(s);
            step(2'b11, start, 1'b0);
            seen = '0;
            for (int n = 1; n <= 7; n++) begin
                step(2'b01, 3'b000, 1'b0);
                if (q == '0 || seen[q]) begin
                    check("R7 state repeated early", q, 3'b111);
                end
                seen[q] = 1'b1;
            end
            check("R7 return after 7", q, start);
            check("R7 all nonzero visited", {2'b00, seen == 8'hFE}, 3'b001);
        end

        // R8 / R6: signature vs model
        model = 3'b100;
        for (int i = 0; i < SIG_LEN; i++) model = ref_sig(model, data_at(i));
        run_sig(-1, 0, sig_a);
        check("R6 signature vs model", sig_a, model);
        for (int c = 0; c < SIG_LEN; c += 7) begin
            for (int b = 0; b < 3; b++) begin
                run_sig(c, b, sig_b);
                check($sformatf("R8 flip cyc %0d bit %0d differs", c, b),
                      {2'b00, sig_b != sig_a}, 3'b001);
            end
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule